// File: doc/BRIEF.md
# Rotate-and-Mask Integer Unit

This execution unit handles the rotate-with-mask instruction family for a 32-bit integer datapath. It rotates a source word left by an amount taken either from an immediate field or from the low bits of a register operand. It then builds a contiguous (possibly wrapping) mask from a begin index and an end index. Finally it either ANDs the rotated word with the mask or merges the rotated bits into a destination word under that mask.

Operands are captured on a valid strobe, and the result appears on the next clock edge together with its own valid flag. When the record option accompanies an operation, a 4-bit condition field is also written. It holds the signed comparison of the result against zero plus a copy of a sticky summary-overflow input. Instruction decode, register file reads and hazard handling sit outside this unit.

Top module: `rotmask_unit`

## Requirements
- R1: The source word is rotated left by the effective amount (0 to 31); bits leaving the most significant end re-enter at the least significant end.
- R2: Bit indices are numbered MSB-first (index 0 is bit 31 of the port, index 31 is bit 0). When the begin index is not above the end index, the mask has ones at every index from begin through end inclusive and zeros elsewhere; rotate 5, begin 4, end 13 yields mask 0x0FFC0000.
- R3: When the begin index exceeds the end index, the mask wraps: ones from begin through index 31 and from index 0 through end.
- R4: With mode_insert_i low, the result is the rotated word ANDed with the mask.
- R5: With mode_insert_i high, rotated bits are copied where the mask is one and bits of dst_i pass through unchanged where the mask is zero.
- R6: With amt_from_reg_i high, the amount is the low 5 bits of amt_reg_i and its upper bits have no effect; with it low, amt_imm_i is used.
- R7: out_valid_o is high exactly in the cycle after a cycle with in_valid_i high. result_o then shows that operation's result and holds its value while no new operation is accepted.
- R8: For an accepted operation with record_i high, cr_wr_o rises together with out_valid_o. cr_o is {lt, gt, eq, so} with lt at bit 3. lt, gt and eq are a signed comparison of the result with zero, and so (bit 0) copies sum_ovf_i.
- R9: After reset, out_valid_o, cr_wr_o, result_o and cr_o are all zero.
- R10: An operation without record_i leaves cr_o unchanged and keeps cr_wr_o low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| in_valid_i | input | 1 | Operation strobe, captures all operands |
| src_i | input | 32 | Word to be rotated |
| dst_i | input | 32 | Current destination word for insert mode |
| amt_imm_i | input | 5 | Immediate rotate amount |
| amt_reg_i | input | 32 | Register-supplied rotate amount |
| amt_from_reg_i | input | 1 | 1 selects amt_reg_i, 0 selects amt_imm_i |
| mask_begin_i | input | 5 | Mask begin index (MSB-first) |
| mask_end_i | input | 5 | Mask end index (MSB-first) |
| mode_insert_i | input | 1 | 0 AND-with-mask, 1 insert-under-mask |
| record_i | input | 1 | Request a condition-field update |
| sum_ovf_i | input | 1 | Sticky summary-overflow bit copied into the field |
| out_valid_o | output | 1 | Result valid |
| result_o | output | 32 | Result word |
| cr_wr_o | output | 1 | Condition field written this cycle |
| cr_o | output | 4 | Condition field {lt, gt, eq, so} |

## Verification
The properties assume that in_valid_i, record_i and the operands settle before the sampling edge and carry known values whenever in_valid_i is high. They also assume that the first cycle after reset is measured against the reset values. The bench changes every input only on the falling clock edge and holds in_valid_i low through reset. It deasserts the strobe between most operations, so the hold and stability properties are exercised as well as the latency property. One back-to-back pair checks that consecutive results each land in their own cycle.

// File: rtl/rotmask_pkg.sv
package rotmask_pkg;

    typedef enum logic {
        MODE_AND    = 1'b0,
        MODE_INSERT = 1'b1
    } merge_mode_e;

    // Condition field, most significant first: lt, gt, eq, so
    typedef struct packed {
        logic lt;
        logic gt;
        logic eq;
        logic so;
    } cond_t;

endpackage

// File: rtl/rotmask_rotl.sv
module rotmask_rotl #(
    parameter int W = 32,
    localparam int SW = $clog2(W)
) (
    input  logic [W-1:0]  data_i,
    input  logic [SW-1:0] amt_i,
    output logic [W-1:0]  data_o
);

    logic [2*W-1:0] dbl;

    always_comb begin
        dbl    = {data_i, data_i} << amt_i;
        data_o = dbl[2*W-1:W];
    end

endmodule

// File: rtl/rotmask_maskgen.sv
module rotmask_maskgen #(
    parameter int W = 32,
    localparam int SW = $clog2(W)
) (
    input  logic [SW-1:0] begin_i,
    input  logic [SW-1:0] end_i,
    output logic [W-1:0]  mask_o
);

    logic wrap;
    assign wrap = begin_i > end_i;

    for (genvar p = 0; p < W; p++) begin : g_bit
        // MSB-first index of port bit p
        localparam logic [SW-1:0] IDX = SW'(W - 1 - p);
        logic above_begin;
        logic below_end;
        assign above_begin = IDX >= begin_i;
        assign below_end   = IDX <= end_i;
        assign mask_o[p]   = wrap ? (above_begin | below_end)
                                  : (above_begin & below_end);
    end

endmodule

// File: rtl/rotmask_cond.sv
module rotmask_cond
    import rotmask_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] value_i,
    input  logic         so_i,
    output cond_t        cond_o
);

    always_comb begin
        cond_o.lt = value_i[W-1];
        cond_o.eq = (value_i == '0);
        cond_o.gt = ~cond_o.lt & ~cond_o.eq;
        cond_o.so = so_i;
    end

endmodule

// File: rtl/rotmask_unit.sv
module rotmask_unit
    import rotmask_pkg::*;
#(
    parameter int W = 32,
    localparam int SW = $clog2(W)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          in_valid_i,
    input  logic [W-1:0]  src_i,
    input  logic [W-1:0]  dst_i,
    input  logic [SW-1:0] amt_imm_i,
    input  logic [W-1:0]  amt_reg_i,
    input  logic          amt_from_reg_i,
    input  logic [SW-1:0] mask_begin_i,
    input  logic [SW-1:0] mask_end_i,
    input  logic          mode_insert_i,
    input  logic          record_i,
    input  logic          sum_ovf_i,
    output logic          out_valid_o,
    output logic [W-1:0]  result_o,
    output logic          cr_wr_o,
    output logic [3:0]    cr_o
);

    typedef struct packed {
        logic         vld;
        logic         crwr;
        logic [W-1:0] res;
        cond_t        cr;
    } state_t;

    state_t st_d, st_q;

    logic [SW-1:0] amt_eff;
    logic [W-1:0]  rot_w, mask_w, merged_w;
    cond_t         cond_w;
    merge_mode_e   mode_w;
    logic          amt_unused_hi;

    // Only the low SW bits of the register amount take part
    assign amt_unused_hi = ^amt_reg_i[W-1:SW];
    assign amt_eff       = amt_from_reg_i ? amt_reg_i[SW-1:0] : amt_imm_i;
    assign mode_w        = merge_mode_e'(mode_insert_i);

    rotmask_rotl #(.W(W)) u_rotl (
        .data_i (src_i),
        .amt_i  (amt_eff),
        .data_o (rot_w)
    );

    rotmask_maskgen #(.W(W)) u_mask (
        .begin_i (mask_begin_i),
        .end_i   (mask_end_i),
        .mask_o  (mask_w)
    );

    always_comb begin
        if (mode_w == MODE_INSERT) merged_w = (rot_w & mask_w) | (dst_i & ~mask_w);
        else                       merged_w = rot_w & mask_w;
    end

    rotmask_cond #(.W(W)) u_cond (
        .value_i (merged_w),
        .so_i    (sum_ovf_i),
        .cond_o  (cond_w)
    );

    always_comb begin
        st_d      = st_q;
        st_d.vld  = in_valid_i;
        st_d.crwr = in_valid_i & record_i;
        if (in_valid_i) begin
            st_d.res = merged_w;
            if (record_i) st_d.cr = cond_w;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign out_valid_o = st_q.vld;
    assign result_o    = st_q.res;
    assign cr_wr_o     = st_q.crwr;
    assign cr_o        = st_q.cr;

endmodule

// File: rtl/rotmask_unit_chk.sv
module rotmask_unit_chk #(
    parameter int W = 32,
    localparam int SW = $clog2(W)
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          in_valid_i,
    input logic [W-1:0]  src_i,
    input logic [SW-1:0] amt_imm_i,
    input logic          amt_from_reg_i,
    input logic [SW-1:0] mask_begin_i,
    input logic [SW-1:0] mask_end_i,
    input logic          mode_insert_i,
    input logic          record_i,
    input logic          out_valid_o,
    input logic [W-1:0]  result_o,
    input logic          cr_wr_o,
    input logic [3:0]    cr_o
);

    AST_VALID_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        in_valid_i |=> out_valid_o); // R7

    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !in_valid_i |=> !out_valid_o); // R7

    AST_RESULT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !in_valid_i |=> $stable(result_o)); // R7

    AST_CRWR_WITH_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cr_wr_o |-> out_valid_o); // R8

    AST_CRWR_ON_RECORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (in_valid_i && record_i) |=> cr_wr_o); // R8

    AST_EQ_MATCHES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cr_wr_o |-> (cr_o[1] == (result_o == '0))); // R8

    AST_LT_MATCHES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cr_wr_o |-> (cr_o[3] == result_o[W-1])); // R8

    AST_ONE_RELATION: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cr_wr_o |-> ($countones(cr_o[3:1]) == 1)); // R8

    AST_CR_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(in_valid_i && record_i) |=> $stable(cr_o)); // R10

    AST_IDENTITY_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (in_valid_i && !mode_insert_i && !amt_from_reg_i && amt_imm_i == '0
         && mask_begin_i == '0 && mask_end_i == SW'(W - 1))
        |=> (result_o == $past(src_i))); // R4

endmodule

bind rotmask_unit rotmask_unit_chk #(.W(W)) u_chk (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .in_valid_i     (in_valid_i),
    .src_i          (src_i),
    .amt_imm_i      (amt_imm_i),
    .amt_from_reg_i (amt_from_reg_i),
    .mask_begin_i   (mask_begin_i),
    .mask_end_i     (mask_end_i),
    .mode_insert_i  (mode_insert_i),
    .record_i       (record_i),
    .out_valid_o    (out_valid_o),
    .result_o       (result_o),
    .cr_wr_o        (cr_wr_o),
    .cr_o           (cr_o)
);

// File: tb/rotmask_unit_tb_top.sv
module rotmask_unit_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 9;

    // {src, dst, amt, begin, end, insert, expected}
    localparam logic [111:0] VECS [NVEC] = '{
        {32'h80000001, 32'h00000000, 5'd1,  5'd0,  5'd31, 1'b0, 32'h00000003},
        {32'h12345678, 32'h00000000, 5'd4,  5'd0,  5'd31, 1'b0, 32'h23456781},
        {32'hFFFFFFFF, 32'h00000000, 5'd5,  5'd4,  5'd13, 1'b0, 32'h0FFC0000},
        {32'h12345678, 32'h00000000, 5'd0,  5'd28, 5'd3,  1'b0, 32'h10000008},
        {32'hFFFFFFFF, 32'h00000000, 5'd0,  5'd0,  5'd0,  1'b0, 32'h80000000},
        {32'h000000AB, 32'h11223344, 5'd8,  5'd16, 5'd23, 1'b1, 32'h1122AB44},
        {32'hFFFFFFFF, 32'h00000000, 5'd0,  5'd31, 5'd0,  1'b1, 32'h80000001},
        {32'h0000000F, 32'h55555555, 5'd30, 5'd0,  5'd31, 1'b1, 32'hC0000003},
        {32'hAABBCCDD, 32'h00000000, 5'd16, 5'd8,  5'd15, 1'b0, 32'h00DD0000}
    };

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        in_valid_i = 1'b0;
    logic [31:0] src_i = '0;
    logic [31:0] dst_i = '0;
    logic [4:0]  amt_imm_i = '0;
    logic [31:0] amt_reg_i = '0;
    logic        amt_from_reg_i = 1'b0;
    logic [4:0]  mask_begin_i = '0;
    logic [4:0]  mask_end_i = '0;
    logic        mode_insert_i = 1'b0;
    logic        record_i = 1'b0;
    logic        sum_ovf_i = 1'b0;
    logic        out_valid_o;
    logic [31:0] result_o;
    logic        cr_wr_o;
    logic [3:0]  cr_o;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk_i = ~clk_i;

    rotmask_unit dut_i (
        .clk_i, .rst_ni, .in_valid_i, .src_i, .dst_i, .amt_imm_i, .amt_reg_i,
        .amt_from_reg_i, .mask_begin_i, .mask_end_i, .mode_insert_i,
        .record_i, .sum_ovf_i, .out_valid_o, .result_o, .cr_wr_o, .cr_o
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [3:0] cr_model(input logic [31:0] r, input logic so);
        return {r[31], (!r[31] && r != 0), (r == 0), so};
    endfunction

    function automatic string vec_req(input int i);
        case (i)
            0, 1:    return "R1";
            2:       return "R2";
            3:       return "R3";
            4, 8:    return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic drive(input logic [31:0] s, input logic [31:0] d,
                         input logic [4:0] ai, input logic [31:0] ar, input logic sel,
                         input logic [4:0] mb, input logic [4:0] me,
                         input logic ins, input logic rec, input logic so);
        src_i = s; dst_i = d; amt_imm_i = ai; amt_reg_i = ar;
        amt_from_reg_i = sel; mask_begin_i = mb; mask_end_i = me;
        mode_insert_i = ins; record_i = rec; sum_ovf_i = so;
    endtask

    initial begin
        logic [3:0] cr_prev;
        repeat (3) @(negedge clk_i);
        // R9: reset state
        check("R9", "valid after reset", {31'b0, out_valid_o}, 32'h0);
        check("R9", "crwr after reset", {31'b0, cr_wr_o}, 32'h0);
        check("R9", "result after reset", result_o, 32'h0);
        check("R9", "cr after reset", {28'b0, cr_o}, 32'h0);
        rst_ni = 1'b1;
        @(negedge clk_i);

        for (int i = 0; i < NVEC; i++) begin
            logic [111:0] v;
            v = VECS[i];
            drive(v[111:80], v[79:48], v[47:43], 32'h0, 1'b0,
                  v[42:38], v[37:33], v[32], 1'b1, i[0]);
            in_valid_i = 1'b1;
            @(negedge clk_i);
            in_valid_i = 1'b0;
            check("R7", "valid one cycle later", {31'b0, out_valid_o}, 32'h1);
            check(vec_req(i), "table result", result_o, v[31:0]);
            check("R8", "crwr on record", {31'b0, cr_wr_o}, 32'h1);
            check("R8", "condition field", {28'b0, cr_o}, {28'b0, cr_model(v[31:0], i[0])});
        end
        cr_prev = cr_o;

        // R6: register amount, only low 5 bits (0xFFFFFFE4 -> 4); R10: no record
        drive(32'h12345678, 32'h0, 5'd0, 32'hFFFFFFE4, 1'b1, 5'd0, 5'd31, 1'b0, 1'b0, 1'b1);
        in_valid_i = 1'b1;
        @(negedge clk_i);
        in_valid_i = 1'b0;
        check("R6", "register amount low bits", result_o, 32'h23456781);
        check("R10", "no crwr without record", {31'b0, cr_wr_o}, 32'h0);
        check("R10", "cr unchanged without record", {28'b0, cr_o}, {28'b0, cr_prev});

        // R7: no strobe -> no valid, result held
        drive(32'hDEADBEEF, 32'h0, 5'd3, 32'h0, 1'b0, 5'd0, 5'd31, 1'b0, 1'b1, 1'b0);
        @(negedge clk_i);
        check("R7", "no valid without strobe", {31'b0, out_valid_o}, 32'h0);
        check("R7", "result held", result_o, 32'h23456781);
        check("R10", "cr held without strobe", {28'b0, cr_o}, {28'b0, cr_prev});

        // R8: zero result with so set
        drive(32'h0, 32'h0, 5'd7, 32'h0, 1'b0, 5'd0, 5'd31, 1'b0, 1'b1, 1'b1);
        in_valid_i = 1'b1;
        @(negedge clk_i);
        in_valid_i = 1'b0;
        check("R8", "zero result field", {28'b0, cr_o}, 32'h3);

        // R7: back-to-back operations
        drive(32'h00000001, 32'h0, 5'd31, 32'h0, 1'b0, 5'd0, 5'd31, 1'b0, 1'b1, 1'b0);
        in_valid_i = 1'b1;
        @(negedge clk_i);
        drive(32'h00000001, 32'hFFFFFFFF, 5'd0, 32'h0, 1'b0, 5'd31, 5'd31, 1'b1, 1'b1, 1'b0);
        check("R1", "first of pair", result_o, 32'h80000000);
        check("R8", "negative field", {28'b0, cr_o}, 32'h8);
        @(negedge clk_i);
        in_valid_i = 1'b0;
        check("R5", "second of pair", result_o, 32'hFFFFFFFF);
        check("R7", "second valid", {31'b0, out_valid_o}, 32'h1);
        @(negedge clk_i);
        check("R7", "valid drops", {31'b0, out_valid_o}, 32'h0);

        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk_i);
            cyc++;
        end
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule